// File: doc/BRIEF.md
# Pixel Position Tracker with Frame Realignment

This block keeps the column and line position of every pixel in a video stream that has a frame sync but no line sync. It runs on the pixel clock. A free-running column counter with a period of 263 clocks marks out the lines. A line counter steps each time the column counter wraps. A single chosen edge of the frame sync input realigns both counters. The column counter is reloaded with a programmable offset, so the recovered image can be moved sideways. The line counter is cleared.

The frame sync input is asynchronous. It passes through a two-flop synchronizer, and an edge is taken where the synchronized level differs from its previous sample. Two one-cycle strobes are produced. One marks the cycle in which a realignment shows on the outputs. The other marks the cycle in which a new line begins.

Top module: `pos_tracker`

## Requirements
- R1: `col_o` stays in the range 0..262. Without a realignment it rises by one every clock, and it returns to 0 after 262.
- R2: Only the edge selected by parameter `VS_EDGE` (EDGE_RISE=1 for a low-to-high change, EDGE_FALL=0 for a high-to-low change) realigns the counters. The effect reaches the outputs on the third rising clock edge after `vsync_i` changes. The opposite edge has no effect.
- R3: On a realignment, `col_o` takes the value of `preload_i`. Values above 262 are clamped to 262.
- R4: On a realignment, `line_o` becomes 0. `frame_start_o` is high for exactly the one cycle in which the reloaded column value first shows.
- R5: When `col_o` wraps from 262 to 0, `line_o` rises by one. `line_wrap_o` is high in that same cycle and in no other cycle.
- R6: If a realignment coincides with the column counter at 262, the realignment wins. `col_o` takes the preload, `line_o` becomes 0, and `line_wrap_o` stays low.
- R7: Without a realignment, `line_o` stops at 2^LINE_W-1 and does not wrap.
- R8: `preload_i` is sampled only at a realignment. Changing it between realignments does not change `col_o`.
- R9: While `rst_ni` is low, `col_o` and `line_o` are 0 and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Frame sync, asynchronous |
| preload_i | input | COL_W | Column value loaded on realignment |
| col_o | output | COL_W | Current column position |
| line_o | output | LINE_W | Current line position |
| frame_start_o | output | 1 | One-cycle strobe on realignment |
| line_wrap_o | output | 1 | One-cycle strobe on start of a new line |

## Verification
The assertions assume that `preload_i` is steady across the cycle in which a realignment is detected. They also assume that sync edges are at least three clocks apart, so the synchronizer never swallows a pulse. The stimulus changes `vsync_i` and `preload_i` only on falling clock edges, and holds each sync level for many cycles. A realignment is timed so that it lands exactly on column 262. A long stretch without any sync drives the line counter into saturation. The bench overrides `LINE_W` to a small value so that saturation is reached within the run.

// File: rtl/pos_tracker_pkg.sv
package pos_tracker_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/vsync_edge_det.sv
module vsync_edge_det
  import pos_tracker_pkg::*;
#(
  parameter int        SYNC_STAGES = 2,
  parameter edge_pol_e VS_EDGE     = EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], vsync_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl = sync_q[SYNC_STAGES-1];

  generate
    if (VS_EDGE == EDGE_RISE) begin : g_rise
      assign edge_o = lvl & ~last_q;
    end else begin : g_fall
      assign edge_o = ~lvl & last_q;
    end
  endgenerate
endmodule

// File: rtl/col_counter.sv
module col_counter #(
  parameter int H_PERIOD = 263,
  parameter int COL_W    = $clog2(H_PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] preload_i,
  output logic [COL_W-1:0] col_o,
  output logic             at_max_o
);
  localparam logic [COL_W-1:0] HMax = COL_W'(H_PERIOD - 1);

  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] load_val;

  assign load_val = (preload_i > HMax) ? HMax : preload_i;
  assign at_max_o = (col_q == HMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       col_q <= '0;
    else if (load_i)   col_q <= load_val;
    else if (at_max_o) col_q <= '0;
    else               col_q <= col_q + COL_W'(1);
  end

  assign col_o = col_q;
endmodule

// File: rtl/line_counter.sv
module line_counter #(
  parameter int LINE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [LINE_W-1:0] LMax = '1;

  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        line_q <= '0;
    else if (clear_i)                   line_q <= '0;
    else if (step_i && line_q != LMax)  line_q <= line_q + LINE_W'(1);
  end

  assign line_o = line_q;
endmodule

// File: rtl/pos_tracker.sv
module pos_tracker
  import pos_tracker_pkg::*;
#(
  parameter int        H_PERIOD    = 263,
  parameter int        LINE_W      = 9,
  parameter int        SYNC_STAGES = 2,
  parameter edge_pol_e VS_EDGE     = EDGE_RISE,
  parameter int        COL_W       = $clog2(H_PERIOD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic [COL_W-1:0]  preload_i,
  output logic [COL_W-1:0]  col_o,
  output logic [LINE_W-1:0] line_o,
  output logic              frame_start_o,
  output logic              line_wrap_o
);
  logic vs_edge;
  logic at_max;
  logic step;
  logic fs_q;
  logic wrap_q;

  vsync_edge_det #(
    .SYNC_STAGES(SYNC_STAGES),
    .VS_EDGE    (VS_EDGE)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vsync_i(vsync_i),
    .edge_o (vs_edge)
  );

  col_counter #(
    .H_PERIOD(H_PERIOD),
    .COL_W   (COL_W)
  ) u_col (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (vs_edge),
    .preload_i(preload_i),
    .col_o    (col_o),
    .at_max_o (at_max)
  );

  // realignment outranks the wrap step
  assign step = at_max & ~vs_edge;

  line_counter #(
    .LINE_W(LINE_W)
  ) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(vs_edge),
    .step_i (step),
    .line_o (line_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q   <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      fs_q   <= vs_edge;
      wrap_q <= step;
    end
  end

  assign frame_start_o = fs_q;
  assign line_wrap_o   = wrap_q;
endmodule

// File: rtl/pos_tracker_chk.sv
module pos_tracker_chk #(
  parameter int H_PERIOD = 263,
  parameter int LINE_W   = 9,
  parameter int COL_W    = $clog2(H_PERIOD)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [COL_W-1:0]  preload_i,
  input logic [COL_W-1:0]  col_o,
  input logic [LINE_W-1:0] line_o,
  input logic              frame_start_o,
  input logic              line_wrap_o
);
  localparam logic [COL_W-1:0]  HMax = COL_W'(H_PERIOD - 1);
  localparam logic [LINE_W-1:0] LMax = '1;

  function automatic logic [COL_W-1:0] clamp(input logic [COL_W-1:0] v);
    return (v > HMax) ? HMax : v;
  endfunction

  assert_col_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_o <= HMax);

  assert_col_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_o != HMax) |=> (frame_start_o || col_o == $past(col_o) + COL_W'(1)));

  assert_preload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> col_o == clamp($past(preload_i)));

  assert_line_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_o == '0);

  assert_wrap_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_o == HMax) |=> (frame_start_o || (line_wrap_o && col_o == '0)));

  assert_wrap_col_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_wrap_o |-> col_o == '0);

  assert_priority_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_start_o && line_wrap_o));

  assert_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o == LMax) |=> (frame_start_o || line_o == LMax));
endmodule

bind pos_tracker pos_tracker_chk #(
  .H_PERIOD(H_PERIOD),
  .LINE_W  (LINE_W),
  .COL_W   (COL_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .preload_i    (preload_i),
  .col_o        (col_o),
  .line_o       (line_o),
  .frame_start_o(frame_start_o),
  .line_wrap_o  (line_wrap_o)
);

// File: tb/pos_tracker_test.sv
module pos_tracker_test;
  import pos_tracker_pkg::*;

  localparam int H_PERIOD = 263;
  localparam int LINE_W   = 6;
  localparam int COL_W    = $clog2(H_PERIOD);
  localparam int HMAX     = H_PERIOD - 1;
  localparam int LMAX     = (1 << LINE_W) - 1;

  typedef struct packed {
    logic [COL_W-1:0]  col;
    logic [LINE_W-1:0] line;
    logic              fs;
    logic              wr;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              vsync_i = 1'b0;
  logic [COL_W-1:0]  preload_i = '0;
  logic [COL_W-1:0]  col_o;
  logic [LINE_W-1:0] line_o;
  logic              frame_start_o;
  logic              line_wrap_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  exp_t q[$];

  // reference state, updated at rising edges
  int   m_col = 0, m_line = 0;
  logic m_fs = 0, m_wr = 0;
  logic s1 = 0, s2 = 0, s3 = 0;

  always #4 clk_i = ~clk_i;

  pos_tracker #(
    .H_PERIOD(H_PERIOD),
    .LINE_W  (LINE_W),
    .VS_EDGE (EDGE_RISE)
  ) uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vsync_i      (vsync_i),
    .preload_i    (preload_i),
    .col_o        (col_o),
    .line_o       (line_o),
    .frame_start_o(frame_start_o),
    .line_wrap_o  (line_wrap_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver side: model from the requirements, pushes expectations
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_col = 0; m_line = 0; m_fs = 0; m_wr = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      logic e;
      exp_t x;
      e = s2 & ~s3;  // R2: rising edge selected
      if (e) begin
        m_col = (int'(preload_i) > HMAX) ? HMAX : int'(preload_i);
        m_line = 0; m_fs = 1; m_wr = 0;
      end else if (m_col == HMAX) begin
        m_col = 0;
        if (m_line != LMAX) m_line = m_line + 1;
        m_fs = 0; m_wr = 1;
      end else begin
        m_col = m_col + 1; m_fs = 0; m_wr = 0;
      end
      s3 = s2; s2 = s1; s1 = vsync_i;
      x.col = COL_W'(m_col); x.line = LINE_W'(m_line); x.fs = m_fs; x.wr = m_wr;
      q.push_back(x);
    end
  end

  // monitor side: pops and compares away from the rising edge
  always @(negedge clk_i) begin
    if (rst_ni && q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      chk(col_o == x.col, "R1/R3 col", int'(col_o), int'(x.col));
      chk(line_o == x.line, "R5/R7 line", int'(line_o), int'(x.line));
      chk(frame_start_o == x.fs, "R4 frame_start", int'(frame_start_o), int'(x.fs));
      chk(line_wrap_o == x.wr, "R5/R6 line_wrap", int'(line_wrap_o), int'(x.wr));
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    summary();
  end

  initial begin
    int rec;
    int rline;
    // R9: reset state
    wait_cycles(3);
    chk(col_o == 0, "R9 col", int'(col_o), 0);
    chk(line_o == 0, "R9 line", int'(line_o), 0);
    chk(!frame_start_o && !line_wrap_o, "R9 strobes", int'(frame_start_o | line_wrap_o), 0);
    rst_ni = 1'b1;

    // R1/R5: free run across several lines
    wait_cycles(600);
    while (!line_wrap_o) @(negedge clk_i);
    chk(col_o == 0, "R5 col at wrap", int'(col_o), 0);

    // R3/R4: realignment with preload 5
    preload_i = 9'd5;
    vsync_i = 1'b1;
    wait_cycles(3);
    chk(col_o == 5, "R3 preload", int'(col_o), 5);
    chk(line_o == 0, "R4 line clear", int'(line_o), 0);
    chk(frame_start_o == 1'b1, "R4 strobe on", int'(frame_start_o), 1);
    wait_cycles(1);
    chk(frame_start_o == 1'b0, "R4 strobe one cycle", int'(frame_start_o), 0);
    chk(col_o == 6, "R1 step", int'(col_o), 6);

    // R8: preload change mid-frame ignored
    preload_i = 9'd100;
    wait_cycles(1);
    chk(col_o == 7, "R8 preload ignored", int'(col_o), 7);

    // R2: falling edge ignored
    vsync_i = 1'b0;
    rec = int'(col_o);
    wait_cycles(4);
    chk(col_o == COL_W'(rec + 4), "R2 other edge", int'(col_o), rec + 4);
    chk(line_o == 0, "R2 line kept", int'(line_o), 0);

    // R3: clamp above 262, then R5 wrap
    preload_i = 9'd300;
    vsync_i = 1'b1;
    wait_cycles(3);
    chk(col_o == HMAX, "R3 clamp", int'(col_o), HMAX);
    wait_cycles(1);
    chk(col_o == 0, "R5 wrap col", int'(col_o), 0);
    chk(line_o == 1, "R5 line step", int'(line_o), 1);
    chk(line_wrap_o == 1'b1, "R5 wrap strobe", int'(line_wrap_o), 1);

    // R6: realignment exactly on column 262
    vsync_i = 1'b0;
    preload_i = 9'd0;
    wait_cycles(300);
    while (m_col != HMAX - 2) @(negedge clk_i);
    rline = int'(line_o);
    vsync_i = 1'b1;
    wait_cycles(2);
    chk(col_o == HMAX, "R6 setup col", int'(col_o), HMAX);
    chk(rline > 0, "R6 setup line", rline, 1);
    wait_cycles(1);
    chk(col_o == 0 && frame_start_o, "R6 reload", int'(col_o), 0);
    chk(line_o == 0, "R6 line cleared", int'(line_o), 0);
    chk(line_wrap_o == 1'b0, "R6 no wrap strobe", int'(line_wrap_o), 0);

    // R7: saturation with no sync
    vsync_i = 1'b0;
    wait_cycles((LMAX + 2) * H_PERIOD);
    chk(line_o == LINE_W'(LMAX), "R7 saturate", int'(line_o), LMAX);
    wait_cycles(H_PERIOD + 5);
    chk(line_o == LINE_W'(LMAX), "R7 held", int'(line_o), LMAX);

    wait_cycles(4);
    summary();
  end
endmodule